// File: doc/BRIEF.md
# Half-Precision Compare, Sign-Inject and Move Unit

This combinational execution unit handles the half-precision operations of a floating-point pipeline that need no arithmetic. Its floating-point register file is 64 bits wide, so a 16-bit half value sits in the low bits of a register entry. The unit receives two FP source registers, one integer source register and an operation code. In the same cycle it returns one register-width result and the accrued exception flags.

The FP sources are checked for correct boxing before use. Any source whose bits above bit 15 are not all ones counts as the canonical quiet NaN. Every half result bound for the FP register file leaves the unit boxed, with all upper bits set. The unit covers these operations:

- three compares: equal, less-than and less-or-equal, each with its own rule for flagging NaN operands;
- three sign-injection variants;
- minimum and maximum, which prefer a numeric operand over a NaN;
- raw bit moves in both directions between the integer and FP register files.

Top module: `hfp_misc_unit`

## Requirements
- R1: `op_i` encodes: 0 equal, 1 less-than, 2 less-or-equal, 3 sign copy, 4 sign invert, 5 sign xor, 6 min, 7 max, 8 FP-to-integer move, 9 integer-to-FP move. Codes 10 to 15 give result 0 and flags 0.
- R2: For operations 0 to 7, an FP source whose bits 63:16 are not all ones is used as the half value 0x7E00, a quiet NaN.
- R3: Equal writes 1 or 0 zero-extended to 64 bits and treats +0 and -0 as equal. A NaN operand gives 0. The invalid flag `fflags_o[4]` is raised only when an operand is a signaling NaN (exponent all ones, fraction nonzero, fraction bit 9 clear). `fflags_o[3:0]` are always 0.
- R4: Less-than and less-or-equal give 0 and raise `fflags_o[4]` when either operand is any NaN.
- R5: Less-than and less-or-equal order ordered operands numerically, including negative values and signed zeros (-0 < +0 is false, -0 <= +0 is true).
- R6: The sign-injection result keeps the exponent and fraction of the first operand. Its sign is taken from the second operand's sign (code 3), the inverse of that sign (code 4), or the XOR of both signs (code 5). The result is boxed and raises no flag.
- R7: When exactly one operand is NaN, min and max return the other operand. When both are NaN they return 0x7E00. Results are boxed, and `fflags_o[4]` is raised when either operand is a signaling NaN.
- R8: Min treats -0 as smaller than +0; max treats +0 as larger than -0.
- R9: The FP-to-integer move copies bits 15:0 of `fs1_i` raw and fills bits 63:16 with copies of bit 15, ignoring boxing. It raises no flag.
- R10: The integer-to-FP move returns bits 15:0 of `xs1_i` with bits 63:16 set to one. It raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| fs1_i | input | 64 | First FP source register |
| fs2_i | input | 64 | Second FP source register |
| xs1_i | input | 64 | Integer source register |
| res_o | output | 64 | Result for the destination register |
| fflags_o | output | 5 | Accrued exception flags, bit 4 invalid |

## Verification
Compares are tried with equal values, with values that differ in sign or in magnitude, with negative pairs and with both zeros. These inputs separate the magnitude order from the sign handling. Quiet and signaling NaNs are applied to each operation family in turn, which tells the equality flag rule apart from the ordered-compare rule and from the min/max preference. Sources with broken boxing show that unboxing applies to every FP operation except the raw move. The move tests pick patterns with bit 15 set and clear, which separates sign extension from zero fill.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int HW      = 16;
  localparam int EXP_W   = 5;
  localparam int FRAC_W  = 10;
  localparam int FLAG_W  = 5;
  localparam int NV_BIT  = 4;
  localparam logic [HW-1:0] CANON_NAN = 16'h7E00;

  typedef enum logic [3:0] {
    OP_EQ       = 4'd0,
    OP_LT       = 4'd1,
    OP_LE       = 4'd2,
    OP_SGN_COPY = 4'd3,
    OP_SGN_FLIP = 4'd4,
    OP_SGN_XOR  = 4'd5,
    OP_MIN      = 4'd6,
    OP_MAX      = 4'd7,
    OP_TO_INT   = 4'd8,
    OP_TO_FP    = 4'd9
  } hfp_op_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } half_info_t;
endpackage

// File: rtl/hfp_unbox.sv
module hfp_unbox
  import hfp_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] raw_i,
  output half_t            val_o,
  output half_info_t       info_o
);
  localparam int BOX_W = REG_W - HW;

  logic  boxed;
  half_t v;

  always_comb begin
    boxed = &raw_i[REG_W-1:HW];
    v     = boxed ? half_t'(raw_i[HW-1:0]) : half_t'(CANON_NAN);
    val_o = v;
    info_o.nan  = (&v.exp) && (|v.frac);
    info_o.snan = (&v.exp) && (|v.frac) && !v.frac[FRAC_W-1];
    info_o.zero = (v.exp == '0) && (v.frac == '0);
  end

  // R2: a source with broken boxing never leaves as anything but the canonical NaN
  always_comb begin
    if (!(&raw_i[REG_W-1:HW]))
      a_r2_unboxed_canon: assert (val_o == CANON_NAN && info_o.nan && !info_o.snan)
        else $error("unbox: broken box not replaced, width %0d", BOX_W);
  end
endmodule

// File: rtl/hfp_cmp.sv
module hfp_cmp
  import hfp_pkg::*;
(
  input  half_t      a_i,
  input  half_t      b_i,
  input  half_info_t a_inf_i,
  input  half_info_t b_inf_i,
  output logic       unord_o,
  output logic       eq_o,
  output logic       lt_o
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [MAG_W-1:0] mag_a, mag_b;
  logic             both_zero, raw_lt, raw_eq;

  always_comb begin
    mag_a     = {a_i.exp, a_i.frac};
    mag_b     = {b_i.exp, b_i.frac};
    both_zero = a_inf_i.zero && b_inf_i.zero;
    if (both_zero)              raw_lt = 1'b0;
    else if (a_i.sign != b_i.sign) raw_lt = a_i.sign;
    else if (!a_i.sign)         raw_lt = mag_a < mag_b;
    else                        raw_lt = mag_a > mag_b;
    raw_eq  = both_zero || (a_i == b_i);
    unord_o = a_inf_i.nan || b_inf_i.nan;
    eq_o    = raw_eq && !unord_o;
    lt_o    = raw_lt && !unord_o;
  end

  // R5: less-than and equal never hold at once
  always_comb begin
    a_r5_lt_eq_excl: assert (!(eq_o && lt_o)) else $error("cmp: lt and eq both set");
  end
endmodule

// File: rtl/hfp_minmax.sv
module hfp_minmax
  import hfp_pkg::*;
(
  input  half_t      a_i,
  input  half_t      b_i,
  input  half_info_t a_inf_i,
  input  half_info_t b_inf_i,
  input  logic       lt_i,
  input  logic       is_max_i,
  output half_t      res_o
);
  logic both_zero, take_a;

  always_comb begin
    both_zero = a_inf_i.zero && b_inf_i.zero;
    if (both_zero) take_a = is_max_i ? !a_i.sign : a_i.sign;
    else           take_a = is_max_i ? !lt_i : lt_i;
    if (a_inf_i.nan && b_inf_i.nan) res_o = half_t'(CANON_NAN);
    else if (a_inf_i.nan)           res_o = b_i;
    else if (b_inf_i.nan)           res_o = a_i;
    else                            res_o = take_a ? a_i : b_i;
  end

  // R7: the pick is always one operand or the canonical NaN
  always_comb begin
    a_r7_pick_source: assert (res_o == a_i || res_o == b_i || res_o == CANON_NAN)
      else $error("minmax: result from nowhere");
  end
endmodule

// File: rtl/hfp_sgnj.sv
module hfp_sgnj
  import hfp_pkg::*;
(
  input  half_t      a_i,
  input  half_t      b_i,
  input  logic [1:0] mode_i,
  output half_t      res_o
);
  always_comb begin
    res_o = a_i;
    unique case (mode_i)
      2'd0:    res_o.sign = b_i.sign;
      2'd1:    res_o.sign = !b_i.sign;
      default: res_o.sign = a_i.sign ^ b_i.sign;
    endcase
  end

  // R6: exponent and fraction pass through untouched
  always_comb begin
    a_r6_body_kept: assert (res_o.exp == a_i.exp && res_o.frac == a_i.frac)
      else $error("sgnj: body altered");
  end
endmodule

// File: rtl/hfp_misc_unit.sv
module hfp_misc_unit
  import hfp_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [3:0]        op_i,
  input  logic [REG_W-1:0]  fs1_i,
  input  logic [REG_W-1:0]  fs2_i,
  input  logic [REG_W-1:0]  xs1_i,
  output logic [REG_W-1:0]  res_o,
  output logic [FLAG_W-1:0] fflags_o
);
  localparam int N_SRC = 2;
  localparam int UP_W  = REG_W - HW;

  logic [REG_W-1:0] src_raw [N_SRC];
  half_t            src_val [N_SRC];
  half_info_t       src_inf [N_SRC];

  assign src_raw[0] = fs1_i;
  assign src_raw[1] = fs2_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_unbox
    hfp_unbox #(.REG_W(REG_W)) u_unbox (
      .raw_i  (src_raw[g]),
      .val_o  (src_val[g]),
      .info_o (src_inf[g])
    );
  end

  logic  unord, eq, lt;
  half_t mm_res, sg_res;
  hfp_op_e op;
  logic    any_snan;

  assign op = hfp_op_e'(op_i);

  hfp_cmp u_cmp (
    .a_i(src_val[0]), .b_i(src_val[1]),
    .a_inf_i(src_inf[0]), .b_inf_i(src_inf[1]),
    .unord_o(unord), .eq_o(eq), .lt_o(lt)
  );

  hfp_minmax u_mm (
    .a_i(src_val[0]), .b_i(src_val[1]),
    .a_inf_i(src_inf[0]), .b_inf_i(src_inf[1]),
    .lt_i(lt), .is_max_i(op == OP_MAX), .res_o(mm_res)
  );

  hfp_sgnj u_sgnj (
    .a_i(src_val[0]), .b_i(src_val[1]),
    .mode_i(op_i[1:0] - 2'd3), .res_o(sg_res)
  );

  always_comb begin
    any_snan = src_inf[0].snan || src_inf[1].snan;
    res_o    = '0;
    fflags_o = '0;
    case (op)
      OP_EQ: begin
        res_o[0]         = eq;
        fflags_o[NV_BIT] = any_snan;
      end
      OP_LT: begin
        res_o[0]         = lt;
        fflags_o[NV_BIT] = unord;
      end
      OP_LE: begin
        res_o[0]         = lt || eq;
        fflags_o[NV_BIT] = unord;
      end
      OP_SGN_COPY, OP_SGN_FLIP, OP_SGN_XOR:
        res_o = {{UP_W{1'b1}}, sg_res};
      OP_MIN, OP_MAX: begin
        res_o            = {{UP_W{1'b1}}, mm_res};
        fflags_o[NV_BIT] = any_snan;
      end
      OP_TO_INT: res_o = {{UP_W{fs1_i[HW-1]}}, fs1_i[HW-1:0]};
      OP_TO_FP:  res_o = {{UP_W{1'b1}}, xs1_i[HW-1:0]};
      default: begin
        res_o    = '0;
        fflags_o = '0;
      end
    endcase
  end

  // Guards next to the output mux
  always_comb begin
    a_r3_only_invalid: assert (fflags_o[NV_BIT-1:0] == '0) else $error("flag other than invalid");
    if (op_i <= 4'd2)
      a_r3_cmp_zext: assert (res_o[REG_W-1:1] == '0) else $error("compare not zero-extended");
    if ((op_i == 4'd1 || op_i == 4'd2) && unord)
      a_r4_unordered: assert (res_o == '0 && fflags_o[NV_BIT]) else $error("unordered compare");
    if (op_i >= 4'd3 && op_i <= 4'd7)
      a_r6_boxed: assert (&res_o[REG_W-1:HW]) else $error("result not boxed");
    if (op_i == 4'd8)
      a_r9_sext: assert (res_o[REG_W-1:HW] == {UP_W{res_o[HW-1]}} && fflags_o == '0)
        else $error("move to integer not sign-extended");
    if (op_i == 4'd9)
      a_r10_box: assert (&res_o[REG_W-1:HW] && res_o[HW-1:0] == xs1_i[HW-1:0])
        else $error("move to FP not boxed");
    if (op_i >= 4'd10)
      a_r1_unused: assert (res_o == '0 && fflags_o == '0) else $error("unused code active");
  end
endmodule

// File: tb/sim_hfp_misc_unit.sv
module sim_hfp_misc_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  op;
  logic [63:0] fs1, fs2, xs1, res;
  logic [4:0]  fl;
  int errors = 0, checks = 0, cyc = 0;

  hfp_misc_unit u0 (.op_i(op), .fs1_i(fs1), .fs2_i(fs2), .xs1_i(xs1),
                    .res_o(res), .fflags_o(fl));

  localparam logic [63:0] H = 64'hFFFF_FFFF_FFFF_0000;
  localparam logic [4:0]  NV = 5'b10000;
  localparam int N = 26;
  localparam logic [3:0]  T_OP  [N] = '{0,0,0,0,1,1,1,2,2,1,2,3,4,5,6,7,6,7,6,7,6,8,8,9,0,3};
  localparam logic [63:0] T_A   [N] = '{H|16'h3C00, H|16'h0000, H|16'h7E00, H|16'h7D00, H|16'h3C00,
    H|16'hC000, H|16'h8000, H|16'h8000, H|16'h7E00, H|16'h3C00, H|16'h4000, H|16'h3C00, H|16'h3C00,
    H|16'hBC00, H|16'h7E00, H|16'h3C00, H|16'h7E00, H|16'h7D00, H|16'h0000, H|16'h8000, H|16'hC000,
    64'h0000_0000_0000_8001, 64'hFFFF_FFFF_FFFF_7BFF, 64'h0, 64'h0000_0000_0000_3C00, 64'h0000_0000_0000_3C00};
  localparam logic [63:0] T_B   [N] = '{H|16'h3C00, H|16'h8000, H|16'h3C00, H|16'h3C00, H|16'h4000,
    H|16'hBC00, H|16'h0000, H|16'h0000, H|16'h3C00, H|16'h7C01, H|16'h3C00, H|16'h8000, H|16'h8000,
    H|16'h8000, H|16'h4000, H|16'h7C01, H|16'h7E00, H|16'h7F00, H|16'h8000, H|16'h0000, H|16'h3C00,
    64'h0, 64'h0, 64'h0, H|16'h3C00, H|16'h8000};
  localparam logic [63:0] T_X   [N] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,
    64'h1234_5678_9ABC_DEF0, 0, 0};
  localparam logic [63:0] T_R   [N] = '{64'd1, 64'd1, 64'd0, 64'd0, 64'd1, 64'd1, 64'd0, 64'd1, 64'd0,
    64'd0, 64'd0, H|16'hBC00, H|16'h3C00, H|16'h3C00, H|16'h4000, H|16'h3C00, H|16'h7E00, H|16'h7E00,
    H|16'h8000, H|16'h0000, H|16'hC000, 64'hFFFF_FFFF_FFFF_8001, 64'h0000_0000_0000_7BFF,
    H|16'hDEF0, 64'd0, H|16'hFE00};
  localparam logic [4:0]  T_F   [N] = '{0,0,0,NV,0,0,0,0,NV,NV,0,0,0,0,0,NV,0,NV,0,0,0,0,0,0,0,0};
  // requirement tags per row
  localparam logic [23:0] T_REQ [N] = '{"R3 ","R3 ","R3 ","R3 ","R5 ","R5 ","R5 ","R5 ","R4 ","R4 ",
    "R5 ","R6 ","R6 ","R6 ","R7 ","R7 ","R7 ","R7 ","R8 ","R8 ","R7 ","R9 ","R9 ","R10","R2 ","R2 "};

  task automatic apply_check(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                             input logic [63:0] x, input logic [63:0] er, input logic [4:0] ef,
                             input logic [23:0] tag);
    @(negedge clk);
    op = o; fs1 = a; fs2 = b; xs1 = x;
    #2;
    checks++;
    if (res !== er || fl !== ef) begin
      errors++;
      $display("FAIL %s op=%0d res=%h flags=%b expected res=%h flags=%b", tag, o, res, fl, er, ef);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = '0; fs1 = '0; fs2 = '0; xs1 = '0;
    // idle state: all-zero inputs are unboxed, so equal sees two quiet NaNs (R2, R3)
    apply_check(4'd0, 64'h0, 64'h0, 64'h0, 64'h0, 5'b0, "R2 ");
    for (int i = 0; i < N; i++)
      apply_check(T_OP[i], T_A[i], T_B[i], T_X[i], T_R[i], T_F[i], T_REQ[i]);
    // R1: unused codes are silent even with signaling NaN inputs
    for (int c = 10; c < 16; c++)
      apply_check(4'(c), H|16'h7D00, H|16'h7D00, 64'hFFFF, 64'h0, 5'b0, "R1 ");
    // R2: each single cleared upper bit breaks the box
    for (int k = 16; k < 64; k += 8)
      apply_check(4'd5, (H|16'h3C00) & ~(64'd1 << k), H|16'h0000, 64'h0, H|16'h7E00, 5'b0, "R2 ");
    // R9: upper bits of the FP source are ignored by the raw move
    apply_check(4'd8, 64'h5555_0000_AAAA_7FFF, 64'h0, 64'h0, 64'h0000_0000_0000_7FFF, 5'b0, "R9 ");
    // R10: bit 15 of the integer source set
    apply_check(4'd9, 64'h0, 64'h0, 64'h0000_0000_0000_8000, H|16'h8000, 5'b0, "R10");
    // R5: less-or-equal on equal negative values, less-than on infinities
    apply_check(4'd2, H|16'hBC00, H|16'hBC00, 64'h0, 64'd1, 5'b0, "R5 ");
    apply_check(4'd1, H|16'hFC00, H|16'h7C00, 64'h0, 64'd1, 5'b0, "R5 ");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule